// File: doc/BRIEF.md
# Symmetric Up/Down PWM Timer

This block is an 8-bit timer that climbs from zero to a ceiling and then falls back to zero. Each trip up and back down is one PWM period. Two compare channels watch the count and drive one output each. A channel's output switches once on the way up and once on the way down, so every pulse sits centred on the zero point of the count and the edges stay symmetric. A prescale selector sets how often the count moves. The ceiling is either the full 8-bit maximum or the channel A compare value.

Compare values are written through a single data bus, with one write strobe per channel. A new value waits in a holding register and goes into use only when the count turns around at its ceiling, so a period never sees a half-applied setting. There are three sticky event flags: zero reached, channel A match and channel B match. Software clears a flag by writing a one to its bit. The interrupt controller clears it by acknowledging the matching request. All pins are plain level signals and none of them has a handshake.

Top module: `pcpwm_timer`

## Requirements
- R1: `clk_sel` picks the timer clock: 0 stops the timer, and codes 1 to 7 advance it once every 1, 8, 32, 64, 128, 256 or 1024 input clocks. While stopped, the count, the outputs and the flags hold their values.
- R2: On each timer clock the count moves up by one until it reaches the ceiling, then down by one until it reaches zero, then up again. One period is twice the ceiling in timer clocks (510 for a ceiling of 255).
- R3: When `top_from_a` is 0 the ceiling is 255. When it is 1 the ceiling is the channel A compare value in use.
- R4: A compare write goes into a holding register. It becomes the value in use only on the timer clock in which the count sits at or above the ceiling while rising, so a period in progress keeps the old value.
- R5: Output mode 2 (non-inverted) drives the pin low after an equal compare while the count rises and high after an equal compare while it falls. For a compare value C between 1 and 254 and a ceiling of 255, the pin is high for 2·C of the 510 timer clocks in each period.
- R6: Output mode 3 drives the exact complement of the mode 2 waveform.
- R7: Output modes 0 and 1 disconnect the waveform, and the pin then stays 0.
- R8: In mode 2, a compare value of 0 holds the pin low and a value of 255 holds it high, with no toggling. Mode 3 holds the opposite levels.
- R9: In mode 2, for a compare value between 1 and 254, a timer clock with the count at zero drives the pin high even when no compare match occurred, which restores the symmetric waveform after a missed match.
- R10: On a timer clock where the count is 0, bit 0 (`flag_ovf`) sets. Where the count equals channel A's or B's value in use, bit 1 (`flag_cmp_a`) or bit 2 (`flag_cmp_b`) sets. Each flag becomes visible in the clock after that timer clock.
- R11: A flag clears in the clock after `flag_clr_we` is high with a 1 at its bit in `flag_clr_mask`, or after its bit in `irq_ack` is high. A set in the same clock wins over a clear.
- R12: `irq_req[i]` is high exactly when flag i is set and `irq_enable[i]` is high, using bit order 0 = zero reached, 1 = channel A match, 2 = channel B match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_sel | input | 3 | Timer clock select (0 = stopped) |
| top_from_a | input | 1 | Ceiling source: 0 = 255, 1 = channel A value in use |
| ocr_a_we | input | 1 | Write strobe for the channel A holding register |
| ocr_b_we | input | 1 | Write strobe for the channel B holding register |
| ocr_wdata | input | 8 | Compare write data |
| out_mode_a | input | 2 | Channel A output mode |
| out_mode_b | input | 2 | Channel B output mode |
| flag_clr_we | input | 1 | Flag clear strobe |
| flag_clr_mask | input | 3 | Flags to clear, one bit per flag |
| irq_enable | input | 3 | Interrupt enable, one bit per flag |
| irq_ack | input | 3 | Interrupt acknowledge, clears the matching flag |
| pwm_a | output | 1 | Channel A waveform |
| pwm_b | output | 1 | Channel B waveform |
| flag_ovf | output | 1 | Zero-reached flag |
| flag_cmp_a | output | 1 | Channel A match flag |
| flag_cmp_b | output | 1 | Channel B match flag |
| irq_req | output | 3 | Interrupt requests |

## Verification
If the count or its direction goes wrong, the pins and flags show it within one timer clock: a pin edge lands in the wrong place, or a flag sets at the wrong time. A stale or early compare value shows up as a pin that does not match the expected level until the next turnaround at the ceiling. A fault in the wave register can stay hidden while a pin is disconnected or parked at a constant level. It then appears on the first timer clock after that pin returns to mode 2 or 3 with a value between 1 and 254. The bench checks every pin and flag on every clock against a behavioural model. It also measures the high time and the number of rising edges in whole-period windows, which catches errors in duty and symmetry.

// File: rtl/ptm_pkg.sv
package ptm_pkg;
  typedef enum logic [1:0] {
    PIN_OFF   = 2'd0,
    PIN_OFF_1 = 2'd1,
    PIN_NONINV = 2'd2,
    PIN_INV   = 2'd3
  } pin_mode_e;

  localparam int unsigned FLG_OVF = 0;
  localparam int unsigned FLG_CA  = 1;
  localparam int unsigned FLG_CB  = 2;
  localparam int unsigned NFLG    = 3;
  localparam int unsigned NCH     = 2;

  // log2 of the divide ratio for each clk_sel code; code 0 is unused (stopped)
  function automatic int unsigned tap_log2(input logic [2:0] sel);
    case (sel)
      3'd1:    return 0;
      3'd2:    return 3;
      3'd3:    return 5;
      3'd4:    return 6;
      3'd5:    return 7;
      3'd6:    return 8;
      default: return 10;
    endcase
  endfunction
endpackage

// File: rtl/ptm_prescale.sv
module ptm_prescale #(
  parameter int unsigned PW = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  output logic       tick
);
  import ptm_pkg::*;

  logic [PW-1:0] div_q;
  logic [PW-1:0] mask;

  always_comb begin
    mask = '0;
    for (int b = 0; b < PW; b++) begin
      if (b < int'(tap_log2(sel))) mask[b] = 1'b1;
    end
  end

  assign tick = (sel != 3'd0) && ((div_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n)              div_q <= '0;
    else if (sel != 3'd0)    div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/ptm_counter.sv
module ptm_counter #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          top_from_a,
  input  logic [CW-1:0] top_alt,
  output logic [CW-1:0] cnt,
  output logic          up,
  output logic          at_top
);
  localparam logic [CW-1:0] MAXV = {CW{1'b1}};

  logic [CW-1:0] top;

  assign top    = top_from_a ? top_alt : MAXV;
  assign at_top = up && (cnt >= top);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (tick) begin
      if (at_top) begin
        up  <= 1'b0;
        cnt <= (cnt == '0) ? '0 : cnt - 1'b1;
      end else if (!up && cnt == '0) begin
        up  <= 1'b1;
        cnt <= (top == '0) ? '0 : CW'(1);
      end else if (up) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/ptm_channel.sv
module ptm_channel #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [CW-1:0] cnt,
  input  logic          up,
  input  logic          load,
  input  logic          wr,
  input  logic [CW-1:0] wdata,
  input  logic [1:0]    mode,
  output logic [CW-1:0] act,
  output logic          match,
  output logic          pin
);
  import ptm_pkg::*;
  localparam logic [CW-1:0] MAXV = {CW{1'b1}};

  logic [CW-1:0] hold_q;
  logic          wave_q;

  assign match = tick && (cnt == act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      act    <= '0;
      wave_q <= 1'b0;
    end else begin
      if (wr) hold_q <= wdata;
      if (tick && load) act <= hold_q;
      if (tick) begin
        if (act == '0)        wave_q <= 1'b0;
        else if (act == MAXV) wave_q <= 1'b1;
        else if (cnt == '0)   wave_q <= 1'b1;
        else if (cnt == act)  wave_q <= ~up;
      end
    end
  end

  always_comb begin
    case (pin_mode_e'(mode))
      PIN_NONINV: pin = wave_q;
      PIN_INV:    pin = ~wave_q;
      default:    pin = 1'b0;
    endcase
  end
endmodule

// File: rtl/ptm_flags.sv
module ptm_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] ack,
  input  logic [N-1:0] en,
  output logic [N-1:0] flags,
  output logic [N-1:0] irq
);
  logic [N-1:0] clr;

  assign clr = (clr_we ? clr_mask : '0) | ack;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)      flags[i] <= 1'b0;
      else if (set[i]) flags[i] <= 1'b1;
      else if (clr[i]) flags[i] <= 1'b0;
    end
    assign irq[i] = flags[i] & en[i];
  end
endmodule

// File: rtl/pcpwm_timer.sv
module pcpwm_timer #(
  parameter int unsigned CW = 8,
  parameter int unsigned PW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    clk_sel,
  input  logic          top_from_a,
  input  logic          ocr_a_we,
  input  logic          ocr_b_we,
  input  logic [CW-1:0] ocr_wdata,
  input  logic [1:0]    out_mode_a,
  input  logic [1:0]    out_mode_b,
  input  logic          flag_clr_we,
  input  logic [2:0]    flag_clr_mask,
  input  logic [2:0]    irq_enable,
  input  logic [2:0]    irq_ack,
  output logic          pwm_a,
  output logic          pwm_b,
  output logic          flag_ovf,
  output logic          flag_cmp_a,
  output logic          flag_cmp_b,
  output logic [2:0]    irq_req
);
  import ptm_pkg::*;

  logic                tick;
  logic [CW-1:0]       cnt_q;
  logic                cnt_up;
  logic                at_top;
  logic [CW-1:0]       act_a_w;
  logic [NCH-1:0]      ch_wr;
  logic [NCH-1:0]      ch_match;
  logic [NCH-1:0]      ch_pin;
  logic [1:0]          ch_mode [NCH];
  logic [CW-1:0]       ch_act  [NCH];
  logic [NFLG-1:0]     flg_set;
  logic [NFLG-1:0]     flg_q;

  assign ch_wr      = {ocr_b_we, ocr_a_we};
  assign ch_mode[0] = out_mode_a;
  assign ch_mode[1] = out_mode_b;
  assign act_a_w    = ch_act[0];

  ptm_prescale #(.PW(PW)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .sel  (clk_sel),
    .tick (tick)
  );

  ptm_counter #(.CW(CW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .top_from_a(top_from_a),
    .top_alt   (act_a_w),
    .cnt       (cnt_q),
    .up        (cnt_up),
    .at_top    (at_top)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ptm_channel #(.CW(CW)) u_ch (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick),
      .cnt  (cnt_q),
      .up   (cnt_up),
      .load (at_top),
      .wr   (ch_wr[c]),
      .wdata(ocr_wdata),
      .mode (ch_mode[c]),
      .act  (ch_act[c]),
      .match(ch_match[c]),
      .pin  (ch_pin[c])
    );
  end

  assign flg_set[FLG_OVF] = tick && (cnt_q == '0);
  assign flg_set[FLG_CA]  = ch_match[0];
  assign flg_set[FLG_CB]  = ch_match[1];

  ptm_flags #(.N(NFLG)) u_flg (
    .clk     (clk),
    .rst_n   (rst_n),
    .set     (flg_set),
    .clr_we  (flag_clr_we),
    .clr_mask(flag_clr_mask),
    .ack     (irq_ack),
    .en      (irq_enable),
    .flags   (flg_q),
    .irq     (irq_req)
  );

  assign pwm_a      = ch_pin[0];
  assign pwm_b      = ch_pin[1];
  assign flag_ovf   = flg_q[FLG_OVF];
  assign flag_cmp_a = flg_q[FLG_CA];
  assign flag_cmp_b = flg_q[FLG_CB];
endmodule

// File: rtl/pcpwm_timer_chk.sv
module pcpwm_timer_chk #(
  parameter int unsigned CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic [CW-1:0] cnt,
  input logic          up,
  input logic [CW-1:0] act_a,
  input logic          top_from_a,
  input logic [1:0]    mode_a,
  input logic          pwm_a,
  input logic          flag_ovf
);
  localparam logic [CW-1:0] MAXV = {CW{1'b1}};
  logic [CW-1:0] top_w;
  assign top_w = top_from_a ? act_a : MAXV;

  // R1
  prescale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  // R2
  count_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && up && cnt < top_w) |=> (cnt == $past(cnt) + 1'b1));

  // R2
  count_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !up && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  // R7
  pin_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_a[1] == 1'b0) |-> !pwm_a);

  // R8
  ocr_zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && act_a == '0) |=> (mode_a != 2'd2 || !pwm_a));

  // R9
  bottom_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == '0 && act_a != '0 && act_a != MAXV) |=> (mode_a != 2'd2 || pwm_a));

  // R10
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == '0) |=> flag_ovf);
endmodule

bind pcpwm_timer pcpwm_timer_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .cnt       (cnt_q),
  .up        (cnt_up),
  .act_a     (act_a_w),
  .top_from_a(top_from_a),
  .mode_a    (out_mode_a),
  .pwm_a     (pwm_a),
  .flag_ovf  (flag_ovf)
);

// File: tb/pcpwm_timer_test.sv
module pcpwm_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] clk_sel = '0;
  logic       top_from_a = 1'b0;
  logic       ocr_a_we = 1'b0, ocr_b_we = 1'b0;
  logic [7:0] ocr_wdata = '0;
  logic [1:0] out_mode_a = '0, out_mode_b = '0;
  logic       flag_clr_we = 1'b0;
  logic [2:0] flag_clr_mask = '0, irq_enable = '0, irq_ack = '0;
  logic       pwm_a, pwm_b, flag_ovf, flag_cmp_a, flag_cmp_b;
  logic [2:0] irq_req;

  int total = 0, bad = 0;
  bit model_on = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pcpwm_timer uut (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .top_from_a(top_from_a),
    .ocr_a_we(ocr_a_we), .ocr_b_we(ocr_b_we), .ocr_wdata(ocr_wdata),
    .out_mode_a(out_mode_a), .out_mode_b(out_mode_b),
    .flag_clr_we(flag_clr_we), .flag_clr_mask(flag_clr_mask),
    .irq_enable(irq_enable), .irq_ack(irq_ack),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .flag_ovf(flag_ovf),
    .flag_cmp_a(flag_cmp_a), .flag_cmp_b(flag_cmp_b), .irq_req(irq_req)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_pdiv, m_cnt, m_bufa, m_bufb, m_acta, m_actb, m_top, m_div;
  bit m_up, m_wa, m_wb, m_tk, m_ld;
  bit [2:0] m_fl, m_set, m_clr;

  function automatic int div_of(input int s);
    int r = 1;
    case (s)
      2: r = 8; 3: r = 32; 4: r = 64; 5: r = 128; 6: r = 256; 7: r = 1024;
      default: r = 1;
    endcase
    return r;
  endfunction

  function automatic bit wave_next(input bit w, input int c, input bit u, input int oc);
    if (oc == 0) return 1'b0;
    if (oc == 255) return 1'b1;
    if (c == 0) return 1'b1;
    if (c == oc) return !u;
    return w;
  endfunction

  function automatic bit pin_of(input bit w, input logic [1:0] md);
    if (md == 2'd2) return w;
    if (md == 2'd3) return !w;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pdiv = 0; m_cnt = 0; m_up = 1; m_bufa = 0; m_bufb = 0;
      m_acta = 0; m_actb = 0; m_wa = 0; m_wb = 0; m_fl = 0;
    end else begin
      m_div = div_of(int'(clk_sel));
      m_tk  = (clk_sel != 0) && ((m_pdiv % m_div) == m_div - 1);
      if (clk_sel != 0) m_pdiv = (m_pdiv + 1) % 1024;
      m_set = 3'b000;
      if (m_tk) begin
        m_top = top_from_a ? m_acta : 255;
        m_set[0] = (m_cnt == 0);
        m_set[1] = (m_cnt == m_acta);
        m_set[2] = (m_cnt == m_actb);
        m_wa = wave_next(m_wa, m_cnt, m_up, m_acta);
        m_wb = wave_next(m_wb, m_cnt, m_up, m_actb);
        m_ld = m_up && (m_cnt >= m_top);
        if (m_ld) begin
          m_up = 0;
          m_cnt = (m_cnt == 0) ? 0 : m_cnt - 1;
          m_acta = m_bufa;
          m_actb = m_bufb;
        end else if (!m_up && m_cnt == 0) begin
          m_up = 1;
          m_cnt = (m_top == 0) ? 0 : 1;
        end else begin
          m_cnt = m_up ? m_cnt + 1 : m_cnt - 1;
        end
      end
      if (ocr_a_we) m_bufa = int'(ocr_wdata);
      if (ocr_b_we) m_bufb = int'(ocr_wdata);
      m_clr = (flag_clr_we ? flag_clr_mask : 3'b000) | irq_ack;
      m_fl = (m_fl & ~m_clr) | m_set;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (model_on && rst_n) begin
      check(pwm_a == pin_of(m_wa, out_mode_a), "R5 R4 pwm_a", int'(pwm_a), int'(pin_of(m_wa, out_mode_a)));
      check(pwm_b == pin_of(m_wb, out_mode_b), "R6 R4 pwm_b", int'(pwm_b), int'(pin_of(m_wb, out_mode_b)));
      check({flag_cmp_b, flag_cmp_a, flag_ovf} == m_fl, "R10 R11 flags",
            int'({flag_cmp_b, flag_cmp_a, flag_ovf}), int'(m_fl));
      check(irq_req == (m_fl & irq_enable), "R12 irq", int'(irq_req), int'(m_fl & irq_enable));
    end
  end

  // ---------------- helpers ----------------
  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_ocr(input bit ch_b, input int v);
    ocr_wdata = 8'(v);
    if (ch_b) ocr_b_we = 1'b1; else ocr_a_we = 1'b1;
    @(negedge clk);
    ocr_a_we = 1'b0; ocr_b_we = 1'b0;
  endtask

  task automatic window(input int n, output int hi_a, output int hi_b, output int rise_a);
    bit prev;
    hi_a = 0; hi_b = 0; rise_a = 0;
    prev = pwm_a;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_a) hi_a++;
      if (pwm_b) hi_b++;
      if (pwm_a && !prev) rise_a++;
      prev = pwm_a;
    end
  endtask

  task automatic clear_flags(input logic [2:0] m);
    flag_clr_we = 1'b1; flag_clr_mask = m;
    @(negedge clk);
    flag_clr_we = 1'b0; flag_clr_mask = '0;
  endtask

  initial begin
    #(8 * 190000);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int ha, hb, ra;
    bit held;
    logic [5:0] snap;
    wait_clk(4);
    // reset state
    check(pwm_a == 1'b0 && pwm_b == 1'b0, "R7 reset pins", int'({pwm_b, pwm_a}), 0);
    check({flag_cmp_b, flag_cmp_a, flag_ovf} == 3'b000, "R10 reset flags",
          int'({flag_cmp_b, flag_cmp_a, flag_ovf}), 0);
    check(irq_req == 3'b000, "R12 reset irq", int'(irq_req), 0);
    rst_n = 1'b1;
    model_on = 1'b1;

    clk_sel = 3'd1; out_mode_a = 2'd2; out_mode_b = 2'd3; irq_enable = 3'b011;
    write_ocr(1'b0, 64);
    write_ocr(1'b1, 200);
    wait_clk(1100);
    window(510, ha, hb, ra);
    check(ha == 128, "R5 duty A=64", ha, 128);
    check(hb == 110, "R6 inverted B=200", hb, 110);
    check(ra == 1, "R2 one rise per 510", ra, 1);

    // flag clear by write
    clear_flags(3'b001);
    while (!flag_ovf) @(negedge clk);
    check(irq_req[0] == 1'b1, "R12 irq follows ovf", int'(irq_req[0]), 1);
    clear_flags(3'b001);
    check(flag_ovf == 1'b0, "R11 write-one clear", int'(flag_ovf), 0);
    // flag clear by ack
    clear_flags(3'b010);
    while (!flag_cmp_a) @(negedge clk);
    irq_ack = 3'b010;
    @(negedge clk);
    irq_ack = 3'b000;
    check(flag_cmp_a == 1'b0, "R11 ack clear", int'(flag_cmp_a), 0);
    while (!flag_cmp_b) @(negedge clk);
    check(irq_req[2] == 1'b0, "R12 disabled irq", int'(irq_req[2]), 0);

    // constant levels
    write_ocr(1'b0, 255);
    wait_clk(1100);
    window(510, ha, hb, ra);
    check(ha == 510, "R8 A=255 constant high", ha, 510);
    // buffered write: no effect until ceiling
    clear_flags(3'b001);
    while (!flag_ovf) @(negedge clk);
    write_ocr(1'b0, 0);
    held = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!pwm_a) held = 1'b0;
    end
    check(held, "R4 old value kept until ceiling", int'(held), 1);
    wait_clk(1100);
    window(510, ha, hb, ra);
    check(ha == 0, "R8 A=0 constant low", ha, 0);
    write_ocr(1'b0, 100);
    wait_clk(1100);
    window(510, ha, hb, ra);
    check(ha == 200 && ra == 1, "R9 symmetric restore A=100", ha, 200);

    // disconnected modes
    out_mode_b = 2'd0;
    window(510, ha, hb, ra);
    check(hb == 0, "R7 mode 0", hb, 0);
    out_mode_b = 2'd1;
    window(510, ha, hb, ra);
    check(hb == 0, "R7 mode 1", hb, 0);

    // ceiling from channel A
    out_mode_b = 2'd2;
    top_from_a = 1'b1;
    write_ocr(1'b1, 50);
    wait_clk(1100);
    window(200, ha, hb, ra);
    check(ha == 100, "R3 A high at ceiling=100", ha, 100);
    check(hb == 100, "R3 B=50 within 200 period", hb, 100);
    check(ra == 1, "R3 period 200", ra, 1);

    // prescaler
    top_from_a = 1'b0;
    write_ocr(1'b0, 64);
    clk_sel = 3'd2;
    wait_clk(9000);
    window(4080, ha, hb, ra);
    check(ha == 1024, "R1 divide by 8 duty", ha, 1024);
    clk_sel = 3'd3;
    wait_clk(3000);
    clk_sel = 3'd0;
    wait_clk(2);
    snap = {pwm_a, pwm_b, flag_ovf, flag_cmp_a, flag_cmp_b, 1'b0};
    held = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if ({pwm_a, pwm_b, flag_ovf, flag_cmp_a, flag_cmp_b, 1'b0} != snap) held = 1'b0;
    end
    check(held, "R1 stopped timer holds", int'(held), 1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule